// File: doc/BRIEF.md
# Link Clock Activity Monitor

This block watches the clock of an incoming serial video link and decides whether that link is running or idle. A link carrying the slowest legal video mode has to be kept apart from a link that has been put into a power-saving state. The block counts link-clock rising edges over a fixed gate window timed by a trusted reference clock. Each window count is compared with a threshold that lies just below the slowest legal pixel clock.

A slow count has to persist for more than one second's worth of windows before the link is declared inactive. A single window at or above the threshold is enough to declare it active again. The edge counter runs in the link domain in Gray code and is sampled into the reference domain. A link clock that has stopped completely therefore still yields a count of zero. A device with two links uses one instance per link.

The reference frequency, the gate length, the inactivity frequency and the highest expected link frequency are all parameters. The threshold count, the number of windows per second and the output count width are derived from them.

Top module: `lclk_activity_mon`

## Requirements
- R1: While reset is held and until the first window ends after reset, link_active is 0, both event pulses are 0 and last_count is 0.
- R2: At the end of each window of GATE_CYCLES reference cycles, last_count takes the number of link-clock rising edges in that window, within one edge for edges that fall on the window boundary.
- R3: A link clock that has stopped, at either level, gives last_count equal to 0 in every window.
- R4: A window whose count is at least the threshold THR = LOW_HZ*GATE_CYCLES/REF_HZ sets link_active at that window's verdict. After the link clock returns, link_active is 1 within two windows plus the synchronizer latency.
- R5: With WPS = REF_HZ/GATE_CYCLES windows per second, link_active falls only on the (WPS+1)-th consecutive window below THR, which is more than one second of low windows. It stays 1 through the first WPS such windows.
- R6: Any window at or above THR clears the run of low windows, so a slow spell shorter than one second never makes link_active fall.
- R7: A link clock at the slowest legal pixel rate, 25.175/22.5 times the inactivity frequency, is always classified active.
- R8: link_went_active is a one-cycle pulse in exactly the cycle in which link_active rises. link_went_inactive is a one-cycle pulse in exactly the cycle in which it falls. The two never occur together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Trusted reference clock that times the gate windows |
| link_clk | input | 1 | Incoming link clock under observation |
| rst_n | input | 1 | Asynchronous active-low reset, synchronized inside to each domain |
| link_active | output | 1 | Level verdict: 1 when the link is judged active |
| link_went_inactive | output | 1 | One reference-cycle pulse when link_active falls |
| link_went_active | output | 1 | One reference-cycle pulse when link_active rises |
| last_count | output | CNT_W | Link-clock edge count of the most recently completed window |

## Verification
The bench builds the block with REF_HZ=160, GATE_CYCLES=16, LOW_HZ=90 and MAX_LINK_HZ=400. This gives a threshold of 9 edges per window, ten windows per second and a 6-bit count. With these values the one-second persistence shrinks to eleven windows of sixteen reference cycles, so the bench can reach both the full fall sequence and a short dip that must not cause a fall. The same values let it sweep link periods from well above to well below the threshold, with the expected count computed arithmetically as the window length divided by the link period. The scaled slowest legal rate, the stopped clock and the boundary band around the threshold all fall within a few thousand cycles.

// File: rtl/lcam_pkg.sv
package lcam_pkg;

   // Edges of input clock expected in a window: hz * cycles / ref_hz
   function automatic longint lcam_scale(longint hz, longint cycles, longint ref_hz);
      return (hz * cycles) / ref_hz;
   endfunction

   typedef struct packed {
      logic went_up;
      logic went_down;
   } lcam_edge_t;

endpackage

// File: rtl/lcam_rst_sync.sv
module lcam_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic srst_n
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain <= '0;
      else         chain <= {chain[STAGES-2:0], 1'b1};
   end

   assign srst_n = chain[STAGES-1];
endmodule

// File: rtl/lcam_gray_cnt.sv
module lcam_gray_cnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] gray
);
   logic [W-1:0] bin_q;
   logic [W-1:0] bin_n;

   assign bin_n = bin_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bin_q <= '0;
         gray  <= '0;
      end else begin
         bin_q <= bin_n;
         gray  <= bin_n ^ (bin_n >> 1);
      end
   end
endmodule

// File: rtl/lcam_gate_meter.sv
module lcam_gate_meter #(
   parameter int CW   = 8,
   parameter int GATE = 16,
   parameter int SYNC = 2,
   localparam int W   = CW + 1,
   localparam int TW  = (GATE > 1) ? $clog2(GATE) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [W-1:0]  gray_async,
   output logic          win_done,
   output logic [CW-1:0] win_count
);
   logic [SYNC-1:0][W-1:0] stg;
   logic [W-1:0]           bin;
   logic [W-1:0]           prev;
   logic [TW-1:0]          tmr;
   logic                   last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[SYNC-2:0], gray_async};
   end

   // Gray to binary: each bit is the parity of itself and all higher bits
   for (genvar i = 0; i < W; i++) begin : g_g2b
      assign bin[i] = ^(stg[SYNC-1] >> i);
   end

   assign last = (tmr == TW'(GATE - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmr       <= '0;
         win_done  <= 1'b0;
         prev      <= '0;
         win_count <= '0;
      end else begin
         tmr      <= last ? '0 : tmr + 1'b1;
         win_done <= last;
         if (last) begin
            prev      <= bin;
            win_count <= CW'(bin - prev);
         end
      end
   end
endmodule

// File: rtl/lcam_verdict.sv
module lcam_verdict
   import lcam_pkg::*;
#(
   parameter int            CW        = 8,
   parameter int            RUN_LIMIT = 11,
   parameter logic [CW-1:0] THR       = 9,
   localparam int           RW        = $clog2(RUN_LIMIT + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          win_done,
   input  logic [CW-1:0] win_count,
   output logic          active,
   output lcam_edge_t    evt,
   output logic [CW-1:0] last_count
);
   logic [RW-1:0] low_run;
   logic          is_high;

   assign is_high = (win_count >= THR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active     <= 1'b0;
         evt        <= '0;
         low_run    <= '0;
         last_count <= '0;
      end else begin
         evt <= '0;
         if (win_done) begin
            last_count <= win_count;
            if (is_high) begin
               low_run <= '0;
               if (!active) begin
                  active      <= 1'b1;
                  evt.went_up <= 1'b1;
               end
            end else begin
               if (low_run != RW'(RUN_LIMIT)) low_run <= low_run + 1'b1;
               if (active && (low_run == RW'(RUN_LIMIT - 1))) begin
                  active        <= 1'b0;
                  evt.went_down <= 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/lclk_activity_mon.sv
module lclk_activity_mon
   import lcam_pkg::*;
#(
   parameter int   REF_HZ       = 50_000_000,
   parameter int   GATE_CYCLES  = 50_000,
   parameter int   LOW_HZ       = 22_500_000,
   parameter int   MAX_LINK_HZ  = 400_000_000,
   parameter int   SYNC_STAGES  = 2,
   localparam longint MAX_CNT   = lcam_scale(MAX_LINK_HZ, GATE_CYCLES, REF_HZ) + 2,
   localparam int   CNT_W       = $clog2(MAX_CNT + 1)
) (
   input  logic             ref_clk,
   input  logic             link_clk,
   input  logic             rst_n,
   output logic             link_active,
   output logic             link_went_inactive,
   output logic             link_went_active,
   output logic [CNT_W-1:0] last_count
);
   localparam longint THR_L = lcam_scale(LOW_HZ, GATE_CYCLES, REF_HZ);
   localparam int     WPS   = REF_HZ / GATE_CYCLES;
   localparam logic [CNT_W-1:0] THR = CNT_W'(THR_L);

   // Elaboration-time parameter checks
   if (GATE_CYCLES < 2) begin : g_bad_gate
      $error("GATE_CYCLES must be at least 2");
   end
   if (THR_L < 1) begin : g_bad_thr
      $error("threshold count must be at least 1");
   end
   if (LOW_HZ >= MAX_LINK_HZ) begin : g_bad_max
      $error("MAX_LINK_HZ must exceed LOW_HZ");
   end
   if (WPS < 1) begin : g_bad_wps
      $error("gate window must not exceed one second");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic                ref_rst_n;
   logic                lnk_rst_n;
   logic [CNT_W:0]      gray_q;
   logic                win_done;
   logic [CNT_W-1:0]    win_count;
   lcam_edge_t          evt;

   lcam_rst_sync #(.STAGES(SYNC_STAGES)) u_ref_rst (
      .clk(ref_clk), .arst_n(rst_n), .srst_n(ref_rst_n)
   );

   lcam_rst_sync #(.STAGES(SYNC_STAGES)) u_lnk_rst (
      .clk(link_clk), .arst_n(rst_n), .srst_n(lnk_rst_n)
   );

   lcam_gray_cnt #(.W(CNT_W + 1)) u_edge_cnt (
      .clk(link_clk), .rst_n(lnk_rst_n), .gray(gray_q)
   );

   lcam_gate_meter #(.CW(CNT_W), .GATE(GATE_CYCLES), .SYNC(SYNC_STAGES)) u_meter (
      .clk(ref_clk), .rst_n(ref_rst_n), .gray_async(gray_q),
      .win_done(win_done), .win_count(win_count)
   );

   lcam_verdict #(.CW(CNT_W), .RUN_LIMIT(WPS + 1), .THR(THR)) u_verdict (
      .clk(ref_clk), .rst_n(ref_rst_n), .win_done(win_done), .win_count(win_count),
      .active(link_active), .evt(evt), .last_count(last_count)
   );

   assign link_went_active   = evt.went_up;
   assign link_went_inactive = evt.went_down;
endmodule

// File: rtl/lcam_checker.sv
module lcam_checker #(
   parameter int            CW   = 8,
   parameter int            GATE = 16,
   parameter int            WPS  = 10,
   parameter logic [CW-1:0] THR  = 9,
   parameter longint        MAXC = 40
) (
   input logic          clk,
   input logic          rst_n,
   input logic          win_done,
   input logic [CW-1:0] win_count,
   input logic          link_active,
   input logic          went_up,
   input logic          went_down,
   input logic [CW-1:0] last_count
);
   localparam longint LIM = longint'(WPS) * GATE;
   localparam int     SW  = $clog2(LIM + 2);

   // Reference cycles since the last window at or above threshold
   logic [SW-1:0] since_high;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              since_high <= '0;
      else if (win_done && (win_count >= THR)) since_high <= '0;
      else if (since_high != SW'(LIM))         since_high <= since_high + 1'b1;
   end

   AST_RISE_HAS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(link_active) |-> went_up);                                   // R8
   AST_UP_PULSE_IS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      went_up |-> $rose(link_active));                                   // R8
   AST_FALL_HAS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(link_active) |-> went_down);                                 // R8
   AST_DOWN_PULSE_IS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      went_down |-> $fell(link_active));                                 // R8
   AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(went_up && went_down));                                          // R8
   AST_RISE_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(link_active) |-> (last_count >= THR));                       // R4
   AST_FALL_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(link_active) |-> (last_count < THR));                        // R5
   AST_FALL_AFTER_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(link_active) |-> (since_high >= SW'(LIM)));                  // R5
   AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      longint'(last_count) <= MAXC);                                     // R2
endmodule

bind lclk_activity_mon lcam_checker #(
   .CW(CNT_W), .GATE(GATE_CYCLES), .WPS(WPS), .THR(THR), .MAXC(MAX_CNT)
) u_lcam_chk (
   .clk(ref_clk), .rst_n(ref_rst_n), .win_done(win_done), .win_count(win_count),
   .link_active(link_active), .went_up(link_went_active),
   .went_down(link_went_inactive), .last_count(last_count)
);

// File: tb/lclk_activity_mon_test.sv
`timescale 1ns/1ps
module lclk_activity_mon_test;
   localparam int CW   = 6;     // 400*16/160 + 2 = 42 -> 6 bits
   localparam int WIN  = 16;    // reference cycles per window
   localparam int WNS  = 320;   // window length in ns (20 ns ref)
   localparam int THR  = 9;     // 90*16/160

   logic          ref_clk = 1'b0;
   logic          link_clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          link_active;
   logic          link_went_inactive;
   logic          link_went_active;
   logic [CW-1:0] last_count;

   int   checks = 0;
   int   failures = 0;
   int   n_rise = 0;
   int   n_fall = 0;
   real  half_ns = 10.0;
   bit   run = 1'b0;
   bit   done = 1'b0;

   lclk_activity_mon #(
      .REF_HZ(160), .GATE_CYCLES(16), .LOW_HZ(90), .MAX_LINK_HZ(400)
   ) uut (
      .ref_clk(ref_clk), .link_clk(link_clk), .rst_n(rst_n),
      .link_active(link_active), .link_went_inactive(link_went_inactive),
      .link_went_active(link_went_active), .last_count(last_count)
   );

   always #10 ref_clk = ~ref_clk;

   initial begin
      #3;
      forever begin
         if (run) begin
            #(half_ns) link_clk = ~link_clk;
         end else begin
            link_clk = 1'b0;
            #(half_ns);
         end
      end
   end

   always @(negedge ref_clk) begin
      if (rst_n) begin
         if (link_went_active)   n_rise++;
         if (link_went_inactive) n_fall++;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge ref_clk);
   endtask

   task automatic set_period(input int p);
      half_ns = p / 2.0;
      run = 1'b1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge ref_clk);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int r0, f0, lo, hi;
      bit stayed;

      // R1: reset state
      cyc(4);
      chk(link_active == 1'b0, "R1", "active in reset", link_active, 0);
      chk(!link_went_active && !link_went_inactive, "R1", "pulses in reset",
          link_went_active + link_went_inactive, 0);
      chk(last_count == 0, "R1", "count in reset", last_count, 0);
      rst_n = 1'b1;
      cyc(6);
      chk(link_active == 1'b0 && last_count == 0, "R1", "state before first window",
          link_active, 0);

      // R4, R8: first fast window brings active with one rise pulse
      set_period(20);
      cyc(3 * WIN + 8);
      chk(link_active == 1'b1, "R4", "active after fast clock", link_active, 1);
      chk(n_rise == 1, "R8", "rise pulse count", n_rise, 1);
      lo = WNS / 20 - 1; hi = WNS / 20 + 1;
      chk(last_count >= lo && last_count <= hi, "R2", "count at 20ns", last_count, WNS / 20);

      // R5: slow clock must keep active through ten windows, then fall
      f0 = n_fall;
      set_period(60);
      stayed = 1'b1;
      for (int i = 0; i < 150; i++) begin
         @(negedge ref_clk);
         if (!link_active) stayed = 1'b0;
      end
      chk(stayed, "R5", "held active through first WPS low windows", stayed, 1);
      cyc(14 * WIN - 150);
      chk(link_active == 1'b0, "R5", "inactive after persistence", link_active, 0);
      chk(n_fall == f0 + 1, "R8", "single fall pulse", n_fall, f0 + 1);

      // R4: prompt return
      set_period(20);
      cyc(2 * WIN + 8);
      chk(link_active == 1'b1, "R4", "prompt return to active", link_active, 1);

      // R6: a short slow dip does not drop the verdict
      f0 = n_fall;
      set_period(60);
      stayed = 1'b1;
      for (int i = 0; i < 6 * WIN; i++) begin
         @(negedge ref_clk);
         if (!link_active) stayed = 1'b0;
      end
      set_period(20);
      for (int i = 0; i < 8 * WIN; i++) begin
         @(negedge ref_clk);
         if (!link_active) stayed = 1'b0;
      end
      chk(stayed && n_fall == f0, "R6", "dip under one second ignored", n_fall, f0);

      // R3: stopped clock
      run = 1'b0;
      cyc(3 * WIN);
      chk(last_count == 0, "R3", "count with stopped clock", last_count, 0);
      cyc(11 * WIN);
      chk(link_active == 1'b0, "R3", "stopped clock inactive", link_active, 0);
      chk(last_count == 0, "R3", "count still zero", last_count, 0);

      // R7: slowest legal pixel rate scaled (31 ns -> ~10.3 edges, threshold 9)
      f0 = n_fall;
      set_period(31);
      cyc(3 * WIN);
      chk(link_active == 1'b1, "R7", "slowest legal rate active", link_active, 1);
      stayed = 1'b1;
      for (int i = 0; i < 14 * WIN; i++) begin
         @(negedge ref_clk);
         if (!link_active) stayed = 1'b0;
      end
      chk(stayed && n_fall == f0, "R7", "slowest legal rate stays active", n_fall, f0);

      // R2, R4, R5: sweep of link periods
      for (int p = 14; p <= 90; p += 2) begin
         set_period(p);
         cyc(14 * WIN);
         lo = WNS / p - 1;
         hi = (WNS + p - 1) / p + 1;
         chk(last_count >= lo && last_count <= hi, "R2", $sformatf("count at %0dns", p),
             last_count, WNS / p);
         if (lo >= THR)
            chk(link_active == 1'b1, "R4", $sformatf("active at %0dns", p), link_active, 1);
         else if (hi < THR)
            chk(link_active == 1'b0, "R5", $sformatf("inactive at %0dns", p), link_active, 0);
      end

      // R8: pulses balance the level
      r0 = n_rise - n_fall;
      chk(r0 == int'(link_active), "R8", "rise minus fall equals level", r0, link_active);

      finish_run();
   end
endmodule